// File: doc/BRIEF.md
# Debug Exception Dispatch Unit

This block sits beside a simple processor pipeline model. It decides what happens to each debug event the pipeline reports. First it filters out data-compare events that must vanish for certain instruction cases. It then records each surviving event in a sticky per-type status register. When the machine-state debug enable is set, it raises a debug interrupt. For every interrupt it produces the return address the handler will later resume at, a flag that says whether the reporting instruction is suppressed, and the handler fetch address.

Events that arrive while debug is disabled remain pending in the status register. A pending event produces a delayed interrupt when the enable later rises. Software clears status bits through a write-one-to-clear port. A separate pulse reports that software turned on internal debug mode while status bits were still set, which is a programming error.

Top module: `dbg_dispatch`

## Requirements
- R1: After reset the status register, the interrupt pulse, the delayed flag, the suppress flag, the store-conditional failure flag, the programming-error flag and both address outputs are all zero.
- R2: Event bits are indexed 0 instruction-address compare, 1 branch-taken, 2 trap, 3 return, 4 data-address compare, 5 data-value compare, 6 instruction-complete. The instruction class is coded 0 other, 1 store-conditional, 2 string, 3 touch. On a store-conditional with no reservation held, bits 4 and 5 are discarded, so they set no status and raise no interrupt. The failure flag pulses in the next cycle.
- R3: On a string instruction with zero length, bit 4 is discarded. Bit 5 is still accepted.
- R4: On a touch instruction, bit 4 is discarded only when that touch is being nulled. Otherwise it is accepted.
- R5: Each accepted event sets its status bit in the next cycle, and the bit then stays set. A clear-port write with mask bit k set clears bit k. When a clear and a new accepted event of the same type fall in one cycle, the bit stays set.
- R6: With the debug enable at 1, any accepted event gives a one-cycle interrupt pulse in the next cycle.
- R7: With the debug enable at 0, no interrupt is raised, and accepted events only latch.
- R8: If the enable goes from 0 to 1 while the status register is nonzero and no event is accepted in that cycle, a delayed interrupt fires in the next cycle. The pulse and the delayed flag are both set, the return address is the current instruction address, and suppress is 0.
- R9: On every interrupt the fetch address equals the vector prefix, then the vector offset, then four zero bits, from most to least significant.
- R10: For instruction-address compare, branch-taken, trap and return, the return address is the current instruction address and suppress is 1.
- R11: For data-address and data-value compare, the asynchronous mode bit selects the result. At 0 the return address is the current address and suppress is 1. At 1 it is the next address and suppress is 0.
- R12: For instruction-complete, the return address is the next instruction address and suppress is 0.
- R13: When several events are accepted together, the return address follows the priority instruction-address compare, then trap/branch/return, then data compare, then instruction-complete.
- R14: If internal debug mode is requested while the status register is nonzero, the programming-error flag pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 7 | Debug event pulses, one per type |
| iclass_i | input | 2 | Class of the reporting instruction |
| resv_held_i | input | 1 | Reservation is held |
| str_len_zero_i | input | 1 | String length is zero |
| touch_nulled_i | input | 1 | Touch instruction is being nulled |
| cur_pc_i | input | ADDR_W | Address of the reporting instruction |
| next_pc_i | input | ADDR_W | Address of the instruction that would execute next |
| dbg_en_i | input | 1 | Machine-state debug enable |
| dac_async_i | input | 1 | Asynchronous data-compare mode |
| vec_prefix_i | input | PFX_W | Handler vector prefix |
| vec_offset_i | input | VOFF_W | Debug vector offset |
| clr_valid_i | input | 1 | Software clear strobe |
| clr_mask_i | input | 7 | Write-one-to-clear mask |
| idm_set_i | input | 1 | Software enables internal debug mode |
| status_o | output | 7 | Sticky debug status |
| irq_take_o | output | 1 | Debug interrupt pulse |
| irq_delayed_o | output | 1 | Interrupt came from pending status |
| suppress_o | output | 1 | Reporting instruction is suppressed |
| save_addr_o | output | ADDR_W | Return address saved for the handler |
| fetch_addr_o | output | ADDR_W | Handler fetch address |
| stcx_fail_o | output | 1 | Store-conditional reports failure |
| prog_err_o | output | 1 | Programming-error pulse |

## Verification
The assertions check the following on every cycle. A status bit that is not being cleared never drops. Data compares on a store-conditional with no reservation leave the status untouched. No interrupt follows a cycle in which debug was disabled. The fetch address always matches the vector inputs. A rising enable over pending status always produces a delayed interrupt. Suppress and the programming-error flag are checked only in the situations that allow them. Only the bench scenarios can show the filtering for zero-length strings and nulled touches, the return address chosen by priority when events coincide, and the switch of the asynchronous mode between the current and next address.

// File: rtl/dbg_pkg.sv
`timescale 1ns/1ps
package dbg_pkg;
  localparam int NEV = 7;
  localparam int EV_IAC  = 0;
  localparam int EV_BRT  = 1;
  localparam int EV_TRAP = 2;
  localparam int EV_RET  = 3;
  localparam int EV_DAC  = 4;
  localparam int EV_DVC  = 5;
  localparam int EV_ICMP = 6;

  typedef enum logic [1:0] {
    CL_OTHER = 2'd0,
    CL_SC    = 2'd1,
    CL_STR   = 2'd2,
    CL_TOUCH = 2'd3
  } iclass_e;
endpackage

// File: rtl/dbg_event_filter.sv
`timescale 1ns/1ps
module dbg_event_filter
  import dbg_pkg::*;
#(
  parameter int N = NEV
) (
  input  logic [N-1:0] ev_i,
  input  logic [1:0]   iclass_i,
  input  logic         resv_held_i,
  input  logic         str_len_zero_i,
  input  logic         touch_nulled_i,
  output logic [N-1:0] acc_o,
  output logic         sc_drop_o
);
  logic sc_nores, str_empty, touch_null;

  always_comb begin
    sc_nores   = (iclass_i == CL_SC) && !resv_held_i;
    str_empty  = (iclass_i == CL_STR) && str_len_zero_i;
    touch_null = (iclass_i == CL_TOUCH) && touch_nulled_i;
    acc_o      = ev_i;
    // R2: lost reservation drops both data compares
    if (sc_nores) begin
      acc_o[EV_DAC] = 1'b0;
      acc_o[EV_DVC] = 1'b0;
    end
    // R3 / R4: address compare only
    if (str_empty || touch_null) acc_o[EV_DAC] = 1'b0;
    sc_drop_o = sc_nores && (ev_i[EV_DAC] || ev_i[EV_DVC]);
  end
endmodule

// File: rtl/dbg_status_reg.sv
`timescale 1ns/1ps
module dbg_status_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[k] <= 1'b0;
      else if (set_i[k]) q_o[k] <= 1'b1;
      else if (clr_i[k]) q_o[k] <= 1'b0;
    end

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (q_o[k] && !clr_i[k]) |=> q_o[k]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> q_o[k]);
  end
endmodule

// File: rtl/dbg_irq_select.sv
`timescale 1ns/1ps
module dbg_irq_select
  import dbg_pkg::*;
#(
  parameter int N      = NEV,
  parameter int ADDR_W = 32
) (
  input  logic [N-1:0]      acc_i,
  input  logic              dac_async_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sup_o
);
  logic grp_ctl, grp_data;

  always_comb begin
    grp_ctl  = acc_i[EV_BRT] | acc_i[EV_TRAP] | acc_i[EV_RET];
    grp_data = acc_i[EV_DAC] | acc_i[EV_DVC];
    // R13: fixed priority
    if (acc_i[EV_IAC] || grp_ctl) begin
      addr_o = cur_pc_i;               // R10
      sup_o  = 1'b1;
    end else if (grp_data) begin
      addr_o = dac_async_i ? next_pc_i : cur_pc_i;  // R11
      sup_o  = !dac_async_i;
    end else begin
      addr_o = next_pc_i;              // R12
      sup_o  = 1'b0;
    end
  end
endmodule

// File: rtl/dbg_dispatch.sv
`timescale 1ns/1ps
module dbg_dispatch
  import dbg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VOFF_W = 12,
  parameter int PFX_W  = ADDR_W - VOFF_W - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEV-1:0]    ev_i,
  input  logic [1:0]        iclass_i,
  input  logic              resv_held_i,
  input  logic              str_len_zero_i,
  input  logic              touch_nulled_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              dbg_en_i,
  input  logic              dac_async_i,
  input  logic [PFX_W-1:0]  vec_prefix_i,
  input  logic [VOFF_W-1:0] vec_offset_i,
  input  logic              clr_valid_i,
  input  logic [NEV-1:0]    clr_mask_i,
  input  logic              idm_set_i,
  output logic [NEV-1:0]    status_o,
  output logic              irq_take_o,
  output logic              irq_delayed_o,
  output logic              suppress_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              stcx_fail_o,
  output logic              prog_err_o
);
  localparam int LOW_W = 4;

  logic [NEV-1:0]    acc, clr_eff;
  logic              sc_drop, dbg_q, take_now, take_del, pending;
  logic [ADDR_W-1:0] sel_addr, vec_addr;
  logic              sel_sup;

  dbg_event_filter #(.N(NEV)) u_filt (
    .ev_i(ev_i), .iclass_i(iclass_i), .resv_held_i(resv_held_i),
    .str_len_zero_i(str_len_zero_i), .touch_nulled_i(touch_nulled_i),
    .acc_o(acc), .sc_drop_o(sc_drop)
  );

  assign clr_eff = clr_valid_i ? clr_mask_i : '0;

  dbg_status_reg #(.N(NEV)) u_stat (
    .clk(clk), .rst(rst), .set_i(acc), .clr_i(clr_eff), .q_o(status_o)
  );

  dbg_irq_select #(.N(NEV), .ADDR_W(ADDR_W)) u_sel (
    .acc_i(acc), .dac_async_i(dac_async_i), .cur_pc_i(cur_pc_i),
    .next_pc_i(next_pc_i), .addr_o(sel_addr), .sup_o(sel_sup)
  );

  assign pending  = |status_o;
  assign take_now = dbg_en_i && (|acc);
  assign take_del = dbg_en_i && !dbg_q && pending && !(|acc);
  assign vec_addr = {vec_prefix_i, vec_offset_i, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q         <= 1'b0;
      irq_take_o    <= 1'b0;
      irq_delayed_o <= 1'b0;
      suppress_o    <= 1'b0;
      save_addr_o   <= '0;
      fetch_addr_o  <= '0;
      stcx_fail_o   <= 1'b0;
      prog_err_o    <= 1'b0;
    end else begin
      dbg_q         <= dbg_en_i;
      irq_take_o    <= take_now || take_del;
      irq_delayed_o <= take_del;
      suppress_o    <= take_now && sel_sup;
      if (take_now)      save_addr_o <= sel_addr;
      else if (take_del) save_addr_o <= cur_pc_i;
      if (take_now || take_del) fetch_addr_o <= vec_addr;
      stcx_fail_o   <= sc_drop;
      prog_err_o    <= idm_set_i && pending;
    end
  end

  p_sc_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (iclass_i == CL_SC && !resv_held_i && !clr_eff[EV_DAC] && !clr_eff[EV_DVC])
    |=> (status_o[EV_DAC] == $past(status_o[EV_DAC]) &&
         status_o[EV_DVC] == $past(status_o[EV_DVC])));
  p_off_noirq_r7: assert property (@(posedge clk) disable iff (rst)
    !dbg_en_i |=> !irq_take_o);
  p_delayed_r8: assert property (@(posedge clk) disable iff (rst)
    (dbg_en_i && !dbg_q && pending && acc == '0) |=> (irq_take_o && irq_delayed_o));
  p_delayed_take_r8: assert property (@(posedge clk) disable iff (rst)
    irq_delayed_o |-> (irq_take_o && !suppress_o));
  p_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> fetch_addr_o == {$past(vec_prefix_i), $past(vec_offset_i), {LOW_W{1'b0}}});
  p_sup_r10: assert property (@(posedge clk) disable iff (rst)
    suppress_o |-> irq_take_o);
  p_prog_r14: assert property (@(posedge clk) disable iff (rst)
    prog_err_o |-> $past(status_o != '0));
endmodule

// File: tb/tb_dbg_dispatch.sv
`timescale 1ns/1ps
module tb_dbg_dispatch;
  localparam int AW = 32, VW = 12, PW = AW - VW - 4, NE = 7;

  logic clk = 0, rst = 1;
  logic [NE-1:0] ev = 0, clr_mask = 0;
  logic [1:0] iclass = 0;
  logic resv = 0, lenz = 0, tnull = 0, den = 0, dasync = 0, clr_v = 0, idm = 0;
  logic [AW-1:0] cur = 0, nxt = 0;
  logic [PW-1:0] pfx = 0;
  logic [VW-1:0] voff = 0;
  logic [NE-1:0] status;
  logic irq, dly, sup, scf, perr;
  logic [AW-1:0] save, fetch;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [NE-1:0] m_st = 0;
  logic m_dq = 0, e_irq = 0, e_dly = 0, e_sup = 0, e_scf = 0, e_perr = 0;
  logic [AW-1:0] e_save = 0, e_fetch = 0;

  always #2.5 clk = ~clk;

  dbg_dispatch #(.ADDR_W(AW), .VOFF_W(VW)) dut (
    .clk(clk), .rst(rst), .ev_i(ev), .iclass_i(iclass), .resv_held_i(resv),
    .str_len_zero_i(lenz), .touch_nulled_i(tnull), .cur_pc_i(cur), .next_pc_i(nxt),
    .dbg_en_i(den), .dac_async_i(dasync), .vec_prefix_i(pfx), .vec_offset_i(voff),
    .clr_valid_i(clr_v), .clr_mask_i(clr_mask), .idm_set_i(idm),
    .status_o(status), .irq_take_o(irq), .irq_delayed_o(dly), .suppress_o(sup),
    .save_addr_o(save), .fetch_addr_o(fetch), .stcx_fail_o(scf), .prog_err_o(perr));

  function automatic logic [NE-1:0] accepted();
    logic [NE-1:0] a = ev;
    if (iclass == 2'd1 && !resv) begin a[4] = 0; a[5] = 0; end
    if (iclass == 2'd2 && lenz) a[4] = 0;
    if (iclass == 2'd3 && tnull) a[4] = 0;
    return a;
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "status", AW'(status), AW'(m_st));
    chk(tag, "irq", AW'(irq), AW'(e_irq));
    chk(tag, "delayed", AW'(dly), AW'(e_dly));
    chk(tag, "suppress", AW'(sup), AW'(e_sup));
    chk(tag, "stcx_fail", AW'(scf), AW'(e_scf));
    chk(tag, "prog_err", AW'(perr), AW'(e_perr));
    chk(tag, "save", save, e_save);
    chk(tag, "fetch", fetch, e_fetch);
  endtask

  task automatic step(string tag);
    logic [NE-1:0] a = accepted();
    logic [NE-1:0] c = clr_v ? clr_mask : '0;
    logic now = den && (a != 0);
    logic del = den && !m_dq && (m_st != 0) && (a == 0);
    logic [AW-1:0] sa; logic ss;
    if (a[0] || a[1] || a[2] || a[3]) begin sa = cur; ss = 1; end
    else if (a[4] || a[5]) begin sa = dasync ? nxt : cur; ss = !dasync; end
    else begin sa = nxt; ss = 0; end
    e_irq = now || del; e_dly = del; e_sup = now && ss;
    if (now) e_save = sa; else if (del) e_save = cur;
    if (now || del) e_fetch = {pfx, voff, 4'b0};
    e_scf = (iclass == 2'd1) && !resv && (ev[4] || ev[5]);
    e_perr = idm && (m_st != 0);
    m_st = (m_st & ~c) | a;
    m_dq = den;
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle();
    ev = 0; iclass = 0; resv = 0; lenz = 0; tnull = 0; clr_v = 0; clr_mask = 0; idm = 0;
  endtask

  task automatic wipe();
    idle(); den = 0; clr_v = 1; clr_mask = '1; step("R5"); clr_v = 0;
  endtask

  initial begin
    cur = 32'h1000; nxt = 32'h1004; pfx = 16'hABCD; voff = 12'h0F0;
    repeat (3) @(posedge clk); #1;
    rst = 0;
    compare("R1");
    // R2: store-conditional without reservation
    den = 1; iclass = 1; resv = 0; ev = 7'b0110000; step("R2");
    idle(); step("R2");
    iclass = 1; resv = 1; ev = 7'b0010000; step("R2");
    wipe();
    // R3: zero-length string drops address compare only
    iclass = 2; lenz = 1; ev = 7'b0110000; step("R3");
    wipe();
    // R4: touch nulled vs not nulled
    iclass = 3; tnull = 1; ev = 7'b0010000; step("R4");
    tnull = 0; step("R4");
    wipe();
    // R7: disabled, events latch
    den = 0; ev = 7'b1000100; step("R7");
    idle(); step("R7");
    // R5: clear and set same bit together
    clr_v = 1; clr_mask = 7'b0000100; ev = 7'b0000100; step("R5");
    idle(); clr_v = 1; clr_mask = 7'b1000000; step("R5");
    idle(); step("R5");
    // R14: internal debug mode with pending status
    idm = 1; step("R14");
    idle(); step("R14");
    // R8: enable rises over pending status
    den = 1; cur = 32'h2220; step("R8");
    step("R8");
    wipe();
    // R9 / R6: prefix and offset in fetch address
    den = 1; pfx = 16'h1234; voff = 12'hFFF; ev = 7'b1000000; step("R9");
    idle(); step("R6");
    // R10 each control event
    for (int k = 0; k < 4; k++) begin
      idle(); ev = NE'(1) << k; cur = 32'h3000 + k * 16; step("R10");
    end
    // R11 async off then on, for both data compares
    for (int m = 0; m < 4; m++) begin
      idle(); dasync = m[0]; ev = m[1] ? 7'b0100000 : 7'b0010000; nxt = 32'h4000 + m * 8; step("R11");
    end
    // R12
    idle(); ev = 7'b1000000; nxt = 32'h5004; step("R12");
    // R13 priority combinations
    idle(); ev = 7'b1110001; dasync = 1; step("R13");
    idle(); ev = 7'b1011000; dasync = 1; step("R13");
    idle(); ev = 7'b1100000; dasync = 1; step("R13");
    // random phase
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      idle();
      for (int b = 0; b < NE; b++) ev[b] = ($urandom % 8) == 0;
      iclass = 2'($urandom); resv = 1'($urandom); lenz = 1'($urandom); tnull = 1'($urandom);
      if ($urandom % 6 == 0) den = ~den;
      dasync = 1'($urandom);
      clr_v = ($urandom % 4) == 0; clr_mask = NE'($urandom);
      idm = ($urandom % 10) == 0;
      cur = $urandom; nxt = $urandom; pfx = PW'($urandom); voff = VW'($urandom);
      step("R13");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule